// File: doc/BRIEF.md
# Shared-SRAM Multi-Queue FIFO Manager

This block runs up to 64 independent hardware FIFO queues that all live in one word-addressed SRAM. Each queue is set up by one packed 32-bit configuration word. The word places the queue's buffer in the SRAM in 16-word blocks, chooses the entry width and the buffer length through small log codes, and sets two power-of-two watermarks. The same word also holds the queue's live read and write pointers. Software reaches the block over a simple single-cycle register bus. It writes a queue's access address to push one word and reads that address to pop one word. Read data comes back registered, one cycle after the request.

The block keeps an entry count for each queue. From it the block derives empty, nearly-empty, nearly-full and full flags. In the lower half of the queues, a push to a full queue or a pop from an empty queue is recorded in sticky error bits that software clears by writing ones. An entry that spans several words is moved over consecutive access cycles, and the queue's pointer and count change only when its last word is moved.

Address map (9-bit word address, bits 8:7 pick the region): `0x000+q` is the configuration word of queue q, `0x080+q` is the access address of queue q, and `0x100+i` is status word i.

Top module: `qm_top`

## Requirements
- R1: After reset, status words 0 to 3 read 0x33333333. Status word 4 (upper-half nearly-empty) reads 0xFFFFFFFF. Status word 5 (upper-half full) and status words 6 and 7 (error bits) read 0. Every configuration word reads 0.
- R2: The configuration word holds the write pointer in bits 6:0, the read pointer in bits 13:7, the base block in bits 21:14, the entry code in bits 23:22, the length code in bits 25:24, the nearly-empty code in bits 28:26 and the nearly-full code in bits 31:29. A read returns the live pointer fields.
- R3: Words pushed to a queue are popped back in the same order. Each queue's data sits at SRAM word (base block × 16) + pointer, and queues do not disturb one another.
- R4: A pointer advances by the entry width in words and wraps by masking with the buffer length minus one. The buffer length is 16, 32, 64 or 128 words for codes 0 to 3.
- R5: Entry code 0, 1 and 2 give entries of 1, 2 and 4 words, and code 3 acts as 4 words. The pointer and the count of a queue change only after the last word of an entry has been moved.
- R6: Capacity is the buffer length divided by the entry width. A watermark code c is 0 entries when c = 0 and 2^(c-1) entries otherwise. The flags are: empty when the count is 0, nearly-empty when the count is at or below the nearly-empty level, nearly-full when the free entries are at or below the nearly-full level, and full when the count equals capacity.
- R7: A push to a full queue writes nothing and leaves the pointer unchanged. On the last word of that entry it sets the queue's overflow bit.
- R8: A pop from an empty queue returns 0 and leaves the pointer unchanged. On the last word of that entry it sets the queue's underflow bit.
- R9: Status words 6 and 7 hold 2 bits per queue for queues 0 to 31, with 16 queues per word: underflow in bit 2k and overflow in bit 2k+1. The bits are sticky, and writing a 1 to a bit clears it.
- R10: Status words 0 to 3 pack one nibble per queue for queues 0 to 31, eight per word, as {full, nearly-full, nearly-empty, empty} from bit 3 down to bit 0. For queues 32 to 63, bit (q−32) of status word 4 is nearly-empty and bit (q−32) of status word 5 is full.
- R11: The read valid output is high exactly in the cycle after each read request, and read data is valid in that cycle.
- R12: Writing a configuration word empties that queue: its count and any partly moved entry are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 9 | Word address (region in bits 8:7) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busRvalid | output | 1 | Read data valid |

## Verification
The bench targets pointer wrap from a preloaded pointer near the end of the buffer. A design that does not mask would walk into the next queue's SRAM and return the wrong words. It checks that the pointer holds still through the first words of a 4-word entry: a design that advances per word would show the queue non-empty after one word and misplace later entries. It pushes past full and pops past empty and checks that no data is written, that 0 comes back, and that the error bit is sticky until written with a one. A design that set or cleared the wrong bit pair would show up in the packed error word. It also checks the packed nibble and bit positions in the lower and upper status words, and that rewriting a configuration word throws away a full queue.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int NUM_Q   = 64;
  localparam int QID_W   = $clog2(NUM_Q);
  localparam int IDX_W   = 7;
  localparam int ADDR_W  = IDX_W + 2;

  localparam logic [1:0] REGION_CFG  = 2'd0;
  localparam logic [1:0] REGION_ACC  = 2'd1;
  localparam logic [1:0] REGION_STAT = 2'd2;

  // control to datapath strobes, one operation per cycle
  typedef struct packed {
    logic              cfgWr;
    logic              cfgRd;
    logic              push;
    logic              pop;
    logic              statRd;
    logic              statWr;
    logic [QID_W-1:0]  qid;
    logic [IDX_W-1:0]  idx;
  } qm_strobe_t;

  // watermark code to entry level: 0 -> 0, c -> 2^(c-1)
  function automatic logic [7:0] wmLevel(input logic [2:0] code);
    return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
  endfunction

  // entry code to log2 of words per entry (code 3 treated as 4 words)
  function automatic logic [1:0] entryLog(input logic [1:0] code);
    return code[1] ? 2'd2 : {1'b0, code[0]};
  endfunction
endpackage

// File: rtl/qm_ctrl.sv
module qm_ctrl
  import qm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output qm_strobe_t        strb,
  output logic              rvalid
);
  logic [1:0] region;
  assign region = busAddr[ADDR_W-1 -: 2];

  always_comb begin
    strb        = '0;
    strb.qid    = busAddr[QID_W-1:0];
    strb.idx    = busAddr[IDX_W-1:0];
    strb.cfgWr  = busValid &&  busWrite && (region == REGION_CFG);
    strb.cfgRd  = busValid && !busWrite && (region == REGION_CFG);
    strb.push   = busValid &&  busWrite && (region == REGION_ACC);
    strb.pop    = busValid && !busWrite && (region == REGION_ACC);
    strb.statRd = busValid && !busWrite && (region == REGION_STAT);
    strb.statWr = busValid &&  busWrite && (region == REGION_STAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rvalid <= 1'b0;
    else       rvalid <= busValid && !busWrite;
  end
endmodule

// File: rtl/qm_dpath.sv
module qm_dpath
  import qm_pkg::*;
#(
  parameter int SRAM_AW = 10
)(
  input  logic             clk,
  input  logic             rstN,
  input  qm_strobe_t       strb,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [NUM_Q-1:0] qEmpty,
  output logic [NUM_Q-1:0] qNearEmpty,
  output logic [NUM_Q-1:0] qNearFull,
  output logic [NUM_Q-1:0] qFull
);
  localparam int SRAM_DEPTH = 1 << SRAM_AW;
  localparam int LOW_Q      = NUM_Q / 2;
  localparam int LQ_W       = $clog2(LOW_Q);
  localparam int LOW_WORDS  = LOW_Q / 8;
  localparam int UO_WORDS   = LOW_Q / 16;
  localparam int UO_FIRST   = LOW_WORDS + 2;

  logic [31:0] cfg     [NUM_Q];
  logic [7:0]  cnt     [NUM_Q];
  logic [1:0]  pushIdx [NUM_Q];
  logic [1:0]  popIdx  [NUM_Q];
  logic [1:0]  uo      [LOW_Q];
  logic [31:0] mem     [SRAM_DEPTH];

  // per-queue occupancy flags
  for (genvar q = 0; q < NUM_Q; q++) begin : g_flag
    logic [7:0] cap;
    assign cap           = (8'd16 << cfg[q][25:24]) >> entryLog(cfg[q][23:22]);
    assign qEmpty[q]     = (cnt[q] == 8'd0);
    assign qFull[q]      = (cnt[q] >= cap);
    assign qNearEmpty[q] = (cnt[q] <= wmLevel(cfg[q][28:26]));
    assign qNearFull[q]  = ((cap - cnt[q]) <= wmLevel(cfg[q][31:29]));
  end

  // packed status words
  logic [31:0] lowStat [LOW_WORDS];
  logic [31:0] uoWord  [UO_WORDS];
  for (genvar w = 0; w < LOW_WORDS; w++) begin : g_low
    for (genvar k = 0; k < 8; k++) begin : g_nib
      assign lowStat[w][k*4 +: 4] = {qFull[w*8+k], qNearFull[w*8+k],
                                     qNearEmpty[w*8+k], qEmpty[w*8+k]};
    end
  end
  for (genvar w = 0; w < UO_WORDS; w++) begin : g_uo
    for (genvar k = 0; k < 16; k++) begin : g_pair
      assign uoWord[w][k*2 +: 2] = uo[w*16+k];
    end
  end

  logic [31:0] statWord;
  always_comb begin
    statWord = '0;
    for (int w = 0; w < LOW_WORDS; w++)
      if (strb.idx == IDX_W'(w)) statWord = lowStat[w];
    if (strb.idx == IDX_W'(LOW_WORDS))     statWord = 32'(qNearEmpty[NUM_Q-1:LOW_Q]);
    if (strb.idx == IDX_W'(LOW_WORDS + 1)) statWord = 32'(qFull[NUM_Q-1:LOW_Q]);
    for (int w = 0; w < UO_WORDS; w++)
      if (strb.idx == IDX_W'(UO_FIRST + w)) statWord = uoWord[w];
  end

  // addressing for the selected queue
  logic [31:0]        cur;
  logic [2:0]         eWords;
  logic [6:0]         ptrMask, wOff, rOff, nextWr, nextRd;
  logic [SRAM_AW-1:0] wAddr, rAddr;
  logic               pushLast, popLast;
  logic [LQ_W-1:0]    lowQid;
  always_comb begin
    cur      = cfg[strb.qid];
    eWords   = 3'd1 << entryLog(cur[23:22]);
    ptrMask  = 7'((8'd16 << cur[25:24]) - 8'd1);
    wOff     = (cur[6:0]  + 7'(pushIdx[strb.qid])) & ptrMask;
    rOff     = (cur[13:7] + 7'(popIdx[strb.qid]))  & ptrMask;
    wAddr    = SRAM_AW'({cur[21:14], 4'b0} + 12'(wOff));
    rAddr    = SRAM_AW'({cur[21:14], 4'b0} + 12'(rOff));
    nextWr   = (cur[6:0]  + 7'(eWords)) & ptrMask;
    nextRd   = (cur[13:7] + 7'(eWords)) & ptrMask;
    pushLast = (3'(pushIdx[strb.qid]) == eWords - 3'd1);
    popLast  = (3'(popIdx[strb.qid])  == eWords - 3'd1);
    lowQid   = strb.qid[LQ_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.push && !qFull[strb.qid]) mem[wAddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_Q; q++) begin
        cfg[q] <= '0; cnt[q] <= '0; pushIdx[q] <= '0; popIdx[q] <= '0;
      end
      for (int i = 0; i < LOW_Q; i++) uo[i] <= '0;
      rdata <= '0;
    end else begin
      if (strb.cfgWr) begin
        cfg[strb.qid]     <= wdata;
        cnt[strb.qid]     <= '0;
        pushIdx[strb.qid] <= '0;
        popIdx[strb.qid]  <= '0;
      end
      if (strb.push) begin
        if (pushLast) begin
          pushIdx[strb.qid] <= '0;
          if (qFull[strb.qid]) begin
            if (int'(strb.qid) < LOW_Q) uo[lowQid][1] <= 1'b1;
          end else begin
            cfg[strb.qid][6:0] <= nextWr;
            cnt[strb.qid]      <= cnt[strb.qid] + 8'd1;
          end
        end else pushIdx[strb.qid] <= pushIdx[strb.qid] + 2'd1;
      end
      if (strb.pop) begin
        if (popLast) begin
          popIdx[strb.qid] <= '0;
          if (qEmpty[strb.qid]) begin
            if (int'(strb.qid) < LOW_Q) uo[lowQid][0] <= 1'b1;
          end else begin
            cfg[strb.qid][13:7] <= nextRd;
            cnt[strb.qid]       <= cnt[strb.qid] - 8'd1;
          end
        end else popIdx[strb.qid] <= popIdx[strb.qid] + 2'd1;
      end
      if (strb.statWr)
        for (int i = 0; i < LOW_Q; i++)
          if (strb.idx == IDX_W'(UO_FIRST + i / 16))
            uo[i] <= uo[i] & ~wdata[(i % 16) * 2 +: 2];
      if (strb.cfgRd)       rdata <= cur;
      else if (strb.pop)    rdata <= qEmpty[strb.qid] ? 32'd0 : mem[rAddr];
      else if (strb.statRd) rdata <= statWord;
    end
  end
endmodule

// File: rtl/qm_top.sv
module qm_top
  import qm_pkg::*;
#(
  parameter int SRAM_AW = 10
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busRvalid
);
  qm_strobe_t       strb;
  logic [NUM_Q-1:0] qEmpty, qNearEmpty, qNearFull, qFull;

  qm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strb(strb), .rvalid(busRvalid)
  );

  qm_dpath #(.SRAM_AW(SRAM_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .rdata(busRdata),
    .qEmpty(qEmpty), .qNearEmpty(qNearEmpty), .qNearFull(qNearFull), .qFull(qFull)
  );
endmodule

// File: rtl/qm_chk.sv
module qm_chk
  import qm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRvalid,
  input logic [NUM_Q-1:0]  qEmpty,
  input logic [NUM_Q-1:0]  qNearEmpty,
  input logic [NUM_Q-1:0]  qNearFull,
  input logic [NUM_Q-1:0]  qFull
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> busRvalid); // R11
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> !busRvalid); // R11
  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (qEmpty & qFull) == '0); // R6
  AST_EMPTY_IS_NEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (qEmpty & ~qNearEmpty) == '0); // R6
  AST_FULL_IS_NEAR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (qFull & ~qNearFull) == '0); // R6
  AST_CFG_WRITE_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr[ADDR_W-1 -: 2] == REGION_CFG)
      |=> qEmpty[$past(busAddr[QID_W-1:0])]); // R12
endmodule

bind qm_top qm_chk u_chk (.*);

// File: tb/tb_qm_top.sv
module tb_qm_top;
  import qm_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              busRvalid;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  qm_top dut (.*);

  function automatic logic [ADDR_W-1:0] cfgA(int q);  return ADDR_W'(9'h000 + q); endfunction
  function automatic logic [ADDR_W-1:0] accA(int q);  return ADDR_W'(9'h080 + q); endfunction
  function automatic logic [ADDR_W-1:0] statA(int i); return ADDR_W'(9'h100 + i); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata; v = busRvalid;
    busValid = 1'b0;
  endtask

  task automatic rdChk(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
    logic [31:0] d; logic v;
    busRd(a, d, v);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) rdChk("R1 low status", statA(i), 32'h3333_3333);
    rdChk("R1 upper near-empty", statA(4), 32'hFFFF_FFFF);
    rdChk("R1 upper full", statA(5), 32'h0);
    rdChk("R1 error word 0", statA(6), 32'h0);
    rdChk("R1 error word 1", statA(7), 32'h0);
    rdChk("R1 config reset", cfgA(17), 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d; logic v;
    busRd(statA(4), d, v);
    chk("R11 rvalid after read", 32'(v), 32'd1);
    busWr(statA(9), 32'h0);
    chk("R11 rvalid low after write", 32'(busRvalid), 32'd0);
  endtask

  // q3: 16 words x 1, nearly-empty level 2, nearly-full level 1, base block 2
  task automatic t_fifo();
    busWr(cfgA(3), 32'h2800_8000);
    for (int i = 0; i < 3; i++) busWr(accA(3), 32'hA000 + i);
    rdChk("R2 write pointer readback", cfgA(3), 32'h2800_8003);
    rdChk("R6 R10 three entries nibble", statA(0), 32'h3333_0333);
    for (int i = 3; i < 15; i++) busWr(accA(3), 32'hA000 + i);
    rdChk("R6 nearly-full at one free", statA(0), 32'h3333_4333);
    busWr(accA(3), 32'hA00F);
    rdChk("R6 full nibble", statA(0), 32'h3333_C333);
    busWr(accA(3), 32'hDEAD);
    rdChk("R7 overflow bit set", statA(6), 32'h0000_0080);
    rdChk("R7 pointer unchanged on overflow", cfgA(3), 32'h2800_8000);
    for (int i = 0; i < 16; i++) rdChk("R3 pop order", accA(3), 32'hA000 + i);
    rdChk("R8 pop empty returns zero", accA(3), 32'h0);
    rdChk("R8 R9 underflow and sticky overflow", statA(6), 32'h0000_00C0);
    busWr(statA(6), 32'h0000_0040);
    rdChk("R9 clear underflow only", statA(6), 32'h0000_0080);
    busWr(statA(6), 32'h0000_0080);
    rdChk("R9 clear overflow", statA(6), 32'h0);
    rdChk("R4 pointers wrapped to zero", cfgA(3), 32'h2800_8000);
  endtask

  // q1: base 0, pointers preset to 14
  task automatic t_wrap();
    busWr(cfgA(1), 32'h0000_070E);
    for (int i = 0; i < 4; i++) busWr(accA(1), 32'hB000 + i);
    rdChk("R4 write pointer wraps", cfgA(1), 32'h0000_0702);
    for (int i = 0; i < 4; i++) rdChk("R3 R4 pop across wrap", accA(1), 32'hB000 + i);
    rdChk("R4 read pointer wraps", cfgA(1), 32'h0000_0102);
  endtask

  // q5: 4-word entries, base block 4, capacity 4 entries
  task automatic t_multi();
    busWr(cfgA(5), 32'h0081_0000);
    for (int i = 0; i < 3; i++) busWr(accA(5), 32'hC000 + i);
    rdChk("R5 no update mid-entry", statA(0), 32'h3333_3333);
    busWr(accA(5), 32'hC003);
    rdChk("R5 status after last word", statA(0), 32'h3303_3333);
    rdChk("R5 pointer moves by 4", cfgA(5), 32'h0081_0004);
    for (int i = 0; i < 3; i++) rdChk("R5 pop words", accA(5), 32'hC000 + i);
    rdChk("R5 read pointer held mid-entry", cfgA(5), 32'h0081_0004);
    rdChk("R5 pop last word", accA(5), 32'hC003);
    rdChk("R5 read pointer after entry", cfgA(5), 32'h0081_0204);
  endtask

  // q40: 2-word entries, base block 8, capacity 8; then reconfigure
  task automatic t_upper();
    busWr(cfgA(40), 32'h0042_0000);
    busWr(accA(40), 32'hD000); busWr(accA(40), 32'hD001);
    rdChk("R10 upper near-empty clears", statA(4), 32'hFFFF_FEFF);
    for (int i = 0; i < 14; i++) busWr(accA(40), 32'hD100 + i);
    rdChk("R10 upper full bit", statA(5), 32'h0000_0100);
    rdChk("R3 q1 data untouched", cfgA(1), 32'h0000_0102);
    busWr(cfgA(40), 32'h0042_0000);
    rdChk("R12 reconfig clears full", statA(5), 32'h0);
    rdChk("R12 reconfig restores near-empty", statA(4), 32'hFFFF_FFFF);
    rdChk("R12 pop after reconfig empty", accA(40), 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_latency();
    t_fifo();
    t_wrap();
    t_multi();
    t_upper();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule